// File: doc/BRIEF.md
# Tagged Receive FIFO with End/Error Lookahead

This block is the receive queue of a serial port. The receiver pushes one byte at a time together with three status tag bits that mark an end-of-frame or a line error. The CPU or a DMA engine pops entries from the other side. Each popped entry returns the byte and its tags as one 11-bit word.

The block does not wait for a tagged byte to reach the head of the queue. It looks at the oldest entries, up to the programmed trigger level, and raises an end/error flag as soon as any of them carries a tag. While that flag is up, the DMA service request is held low and an interrupt is raised that software cannot mask. Software must then drain the queue by CPU reads. When the tagged entries are gone, the flag falls and DMA requests resume on their own.

Without a pending tag, the DMA request follows a threshold: occupancy must reach the trigger level. A write to a full queue is dropped and recorded in a sticky overrun bit.

Top module: `tagrx_fifo`

## Requirements
- R1: Entries leave in the order they were written; a read word carries the data byte in bits 7..0 and the three tag bits in bits 10..8.
- R2: `rd_data` shows the popped word from the cycle after the clock edge that accepts `rd_en`, and holds until the next read.
- R3: `eif` is 1 when any entry among the oldest min(`level`, effective trigger) occupied entries has a nonzero tag. The entry exactly at the trigger position counts. Status outputs reflect the queue state one clock after it changes.
- R4: `eif` falls by itself, with no software action, once no entry in that window carries a tag, for example after the tagged entries have been read out.
- R5: While `eif` is 1, `dma_req` is 0 and `irq` is 1; `irq` has no enable and always equals `eif`.
- R6: While `eif` is 0, `dma_req` is 1 exactly when the occupancy is at least the effective trigger level.
- R7: A `trig_level` of 0 acts as 1, and a value above DEPTH (32) acts as DEPTH.
- R8: A write while 32 entries are held is dropped and sets `overrun`. `overrun` stays set until a cycle with `ovr_clr` high; if a drop occurs in the same cycle as `ovr_clr`, the drop wins.
- R9: A read from an empty queue returns 0 on `rd_data` and leaves the occupancy and order unchanged.
- R10: `level` gives the number of held entries (0..32) right after the edge that changes it.
- R11: After a synchronous reset the queue is empty and `eif`, `irq`, `dma_req`, `overrun` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one entry |
| wr_data | input | 8 | Received byte |
| wr_tag | input | 3 | End/error tag bits for the byte |
| rd_en | input | 1 | Pop one entry |
| rd_data | output | 11 | Popped entry: tags in bits 10..8, byte in bits 7..0 |
| trig_level | input | 6 | Trigger level, effective range 1..32 |
| ovr_clr | input | 1 | Clears the overrun bit (write-one-to-clear) |
| level | output | 6 | Current occupancy |
| eif | output | 1 | End/error within the trigger window (read-only status) |
| dma_req | output | 1 | Receive DMA service request |
| irq | output | 1 | Unmaskable end/error interrupt |
| overrun | output | 1 | Sticky overrun status |

## Verification
The hardest case is a tag that lies inside the window but not at the head. A second hard case is a tag that sits just past the trigger position and only enters the window after reads shift it. The stimulus table fills the queue with eight entries and places one tag at chosen positions. It then pops a chosen number of entries before sampling, so the boundary slot is covered from both sides and a window narrowed by low occupancy is reached. The clamped trigger values are used with the same fill.

// File: rtl/tagrx_pkg.sv
package tagrx_pkg;
  localparam int DATA_W  = 8;
  localparam int TAG_W   = 3;
  localparam int ENTRY_W = DATA_W + TAG_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/tagrx_ram.sv
// Simple dual-port storage with a registered read, shaped for block RAM.
module tagrx_ram #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/tagrx_scan.sv
// Parallel lookahead: is any marked slot within the oldest `window` entries?
module tagrx_scan #(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] marks,
  input  logic [PTR_W-1:0] head,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] trig,
  output logic             hit
);
  logic [CNT_W-1:0] window;
  logic [DEPTH-1:0] in_win;

  assign window = (count < trig) ? count : trig;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [PTR_W-1:0] SLOT = PTR_W'(g);
    logic [PTR_W-1:0] age;
    assign age       = SLOT - head;
    assign in_win[g] = marks[g] && (CNT_W'(age) < window);
  end

  assign hit = |in_win;

  // R3: a hit needs at least one occupied entry
  always_comb begin
    if (hit) assert_hit_needs_entry_R3: assert (count != '0);
  end
endmodule

// File: rtl/tagrx_fifo.sv
module tagrx_fifo
  import tagrx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  input  logic [CNT_W-1:0]   trig_level,
  input  logic               ovr_clr,
  output logic [CNT_W-1:0]   level,
  output logic               eif,
  output logic               dma_req,
  output logic               irq,
  output logic               overrun
);
  // DEPTH must be a power of two so that pointers wrap naturally.
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count_q;
  logic [DEPTH-1:0]   mark_q;
  logic               wr_ok, rd_ok, wr_drop;
  logic [CNT_W-1:0]   trig_eff;
  logic               scan_hit;
  logic               rd_hit_q;
  logic [ENTRY_W-1:0] ram_q;
  logic               eif_q, irq_q, dma_q, ovr_q;
  rx_entry_t          wr_entry;

  assign wr_ok   = wr_en && (count_q != FULL);
  assign wr_drop = wr_en && (count_q == FULL);
  assign rd_ok   = rd_en && (count_q != '0);

  assign trig_eff = (trig_level == '0) ? CNT_W'(1) :
                    (trig_level > FULL) ? FULL : trig_level;

  assign wr_entry.tag  = wr_tag;
  assign wr_entry.data = wr_data;

  tagrx_ram #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wr_ptr),
    .wdata (wr_entry),
    .re    (rd_ok),
    .raddr (rd_ptr),
    .rdata (ram_q)
  );

  tagrx_scan #(.DEPTH(DEPTH)) u_scan (
    .marks (mark_q),
    .head  (rd_ptr),
    .count (count_q),
    .trig  (trig_eff),
    .hit   (scan_hit)
  );

  // Pointers, occupancy and one "tagged" mark per slot
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      mark_q  <= '0;
    end else begin
      if (wr_ok) begin
        wr_ptr         <= wr_ptr + 1'b1;
        mark_q[wr_ptr] <= |wr_tag;
      end
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
      count_q <= count_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
    end
  end

  // Read-return qualifier: an empty pop yields zero
  always_ff @(posedge clk) begin
    if (rst)        rd_hit_q <= 1'b0;
    else if (rd_en) rd_hit_q <= rd_ok;
  end

  // Registered status
  always_ff @(posedge clk) begin
    if (rst) begin
      eif_q <= 1'b0;
      irq_q <= 1'b0;
      dma_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      eif_q <= scan_hit;
      irq_q <= scan_hit;
      dma_q <= !scan_hit && (count_q >= trig_eff);
      if (wr_drop)      ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end

  assign rd_data = rd_hit_q ? ram_q : '0;
  assign level   = count_q;
  assign eif     = eif_q;
  assign irq     = irq_q;
  assign dma_req = dma_q;
  assign overrun = ovr_q;

  assert_err_blocks_dma_R5: assert property (@(posedge clk) disable iff (rst)
    scan_hit |=> (eif && irq && !dma_req));

  assert_flag_falls_R4: assert property (@(posedge clk) disable iff (rst)
    !scan_hit |=> (!eif && !irq));

  assert_dma_threshold_R6: assert property (@(posedge clk) disable iff (rst)
    (!scan_hit && count_q >= trig_eff) |=> dma_req);

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (count_q == FULL && wr_en && !rd_en) |=> (overrun && level == FULL));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0 && rd_en && !wr_en) |=> (level == '0 && $stable(rd_ptr) && rd_data == '0));

  assert_level_bound_R10: assert property (@(posedge clk) disable iff (rst)
    level <= FULL);
endmodule

// File: tb/tagrx_fifo_tb.sv
module tagrx_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  wr_tag = '0;
  logic [5:0]  trig_level = 6'd4;
  logic [10:0] rd_data;
  logic [5:0]  level;
  logic        eif, dma_req, irq, overrun;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tagrx_fifo u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_en(rd_en), .rd_data(rd_data), .trig_level(trig_level), .ovr_clr(ovr_clr),
    .level(level), .eif(eif), .dma_req(dma_req), .irq(irq), .overrun(overrun)
  );

  // Vector: {trig[5:0], tag mask over 8 writes [7:0], reads before sampling [3:0], eif, dma}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {6'd4,  8'h00, 4'd0, 1'b0, 1'b1},   // no tags, count 8 >= 4
    {6'd4,  8'h08, 4'd0, 1'b1, 1'b0},   // tag at slot 3 = trigger boundary
    {6'd4,  8'h10, 4'd0, 1'b0, 1'b1},   // tag just outside window
    {6'd4,  8'h01, 4'd1, 1'b0, 1'b1},   // tagged head read out
    {6'd4,  8'h10, 4'd1, 1'b1, 1'b0},   // window slid onto tag
    {6'd16, 8'h80, 4'd0, 1'b1, 1'b0},   // window limited by occupancy
    {6'd16, 8'h00, 4'd0, 1'b0, 1'b0},   // below threshold
    {6'd8,  8'h00, 4'd0, 1'b0, 1'b1},   // exactly at threshold
    {6'd0,  8'h02, 4'd0, 1'b0, 1'b1},   // trig 0 acts as 1
    {6'd0,  8'h01, 4'd0, 1'b1, 1'b0},
    {6'd63, 8'h00, 4'd0, 1'b0, 1'b0},   // trig 63 acts as 32
    {6'd63, 8'h40, 4'd0, 1'b1, 1'b0},
    {6'd2,  8'h04, 4'd2, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] t);
    wr_en = 1'b1; wr_data = d; wr_tag = t;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [10:0] v);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    v = rd_data;
  endtask

  function automatic logic [2:0] tag_of(input int i, input logic [7:0] mask);
    return mask[i] ? (3'b001 << (i % 3)) : 3'b000;
  endfunction

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] v;
    tick();
    do_reset();
    tick();
    // R11: reset state
    chk("R11 level", level, 0);
    chk("R11 flags", {eif, irq, dma_req, overrun}, 4'b0000);
    chk("R11 rd_data", rd_data, 0);

    // Table-driven window and threshold cases
    for (int n = 0; n < NV; n++) begin
      logic [5:0] tv; logic [7:0] mv; logic [3:0] rv; logic ev, dv;
      {tv, mv, rv, ev, dv} = VEC[n];
      do_reset();
      trig_level = tv;
      for (int i = 0; i < 8; i++) push(8'h10 + 8'(i), tag_of(i, mv));
      for (int i = 0; i < int'(rv); i++) begin
        pop(v);
        chk("R1 table data", v, {tag_of(i, mv), 8'h10 + 8'(i)});
      end
      tick(); tick();
      chk($sformatf("R3 eif vector %0d", n), eif, ev);
      chk($sformatf("R5 irq vector %0d", n), irq, ev);
      chk($sformatf("R6 dma vector %0d", n), dma_req, dv);
      if (tv == 0 || tv == 63) chk($sformatf("R7 clamp vector %0d", n), {eif, dma_req}, {ev, dv});
    end

    // R4: flag falls after tagged head is drained, DMA resumes
    do_reset();
    trig_level = 6'd1;
    push(8'hA0, 3'b100);
    push(8'hA1, 3'b000);
    tick(); tick();
    chk("R5 eif with tagged head", {eif, irq, dma_req}, 3'b110);
    pop(v);
    chk("R1 tag in bits 10..8", v, 11'h4A0);
    tick(); tick();
    chk("R4 eif falls after drain", {eif, irq, dma_req}, 3'b001);
    // R2: read data holds until next read
    tick(); tick();
    chk("R2 rd_data holds", rd_data, 11'h4A0);

    // R9: empty read
    do_reset();
    push(8'h55, 3'b000);
    pop(v);
    chk("R1 single", v, 11'h055);
    pop(v);
    chk("R9 empty read zero", v, 0);
    chk("R9 level unchanged", level, 0);
    push(8'h66, 3'b000);
    pop(v);
    chk("R9 order kept after empty read", v, 11'h066);

    // R8/R10: fill, overflow, clear, drain
    do_reset();
    trig_level = 6'd32;
    for (int i = 0; i < 32; i++) begin
      push(8'(i * 7), 3'b000);
    end
    chk("R10 full level", level, 32);
    chk("R8 no overrun yet", overrun, 1'b0);
    push(8'hFF, 3'b001);
    chk("R8 drop keeps level", level, 32);
    chk("R8 overrun set", overrun, 1'b1);
    tick();
    chk("R8 overrun sticky", overrun, 1'b1);
    chk("R6 full dma", dma_req, 1'b1);
    chk("R3 dropped tag ignored", eif, 1'b0);
    ovr_clr = 1'b1; wr_en = 1'b1; wr_tag = 3'b000;
    tick();
    ovr_clr = 1'b0; wr_en = 1'b0;
    chk("R8 drop wins over clear", overrun, 1'b1);
    ovr_clr = 1'b1;
    tick();
    ovr_clr = 1'b0;
    chk("R8 overrun cleared", overrun, 1'b0);
    for (int i = 0; i < 32; i++) begin
      pop(v);
      chk("R1 full drain order", v, {3'b000, 8'(i * 7)});
    end
    chk("R10 empty after drain", level, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule